// File: doc/BRIEF.md
# Inter-Stage Dependency Token Synchronizer

This block sets the order in which the three stages of an accelerator pipeline run: load, compute and store. Each instruction a stage wants to run arrives with four dependency flags. Two flags name tokens the instruction must take from a neighbour before it may start. The other two name tokens it hands to a neighbour once it has finished. The block keeps one token counter for each direction between neighbouring stages: load to compute, compute to load, compute to store, and store to compute. The flag names are relative to the issuing stage. For the compute stage, "previous" means load and "next" means store. The load stage has no previous neighbour and the store stage has no next neighbour.

A stage presents an instruction by holding `issue_valid` high with its flags. The block raises `start` for that stage in the same cycle, as soon as every token it needs is present, and it removes those tokens at the clock edge that ends that cycle. The stage then stays busy until it raises `done`. At that point the block acknowledges with `done_ack`, which is also the cycle in which the tokens are pushed. A long instruction therefore pushes its tokens once, no matter how many cycles it runs.

Top module: `dep_token_sync`

## Requirements
- R1: After a synchronous reset, all four token counters are empty and all stages are idle. An instruction that needs a token is not started, and a `done` from an idle stage is not acknowledged.
- R2: An idle stage issuing an instruction with all four flags clear sees `start` high in the same cycle. The instruction moves no tokens.
- R3: `start` stays low until every counter the instruction pops holds at least one token. In the grant cycle, one token is taken from each such counter. An instruction that pops two counters needs both to be non-empty.
- R4: Pushes happen only in the cycle where `done_ack` is high, exactly once per instruction. They use the flags captured at grant, however many cycles the stage stays busy.
- R5: Flags are bits [4s+3:4s] of `issue_flags` for stage s (load=0, compute=1, store=2). Within a stage's field, bit 3 is pop-previous, bit 2 is pop-next, bit 1 is push-previous and bit 0 is push-next. A compute instruction with push-previous adds to the compute-to-load counter, which a load instruction with pop-next consumes.
- R6: A load instruction with push-next adds to the load-to-compute counter, which compute pop-previous consumes. Compute push-next feeds the compute-to-store counter, which store pop-previous consumes. Store push-previous feeds the store-to-compute counter, which compute pop-next consumes.
- R7: Each counter holds up to 8 tokens. When a pushed counter is full, `done_ack` is held low, and it rises in the cycle after a pop makes room.
- R8: A push and a pop on the same counter in the same cycle leave its token count unchanged.
- R9: A busy stage gets no new `start`. The load stage's pop-previous and push-previous flags and the store stage's pop-next and push-next flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 3 | Per-stage instruction presented (bit 0 load, 1 compute, 2 store) |
| issue_flags | input | 12 | Per-stage dependency flags, 4 bits per stage |
| start | output | 3 | Per-stage start grant; pops happen at the end of this cycle |
| done | input | 3 | Per-stage completion of the running instruction |
| done_ack | output | 3 | Per-stage completion accepted; pushes happen at the end of this cycle |

## Verification
Two pairs of events can fall in the same cycle. In the first, one stage is granted a start that pops a counter while another stage's completion pushes to that same counter. The bench sets this up by holding compute's `done` and issuing a load pop-next in one cycle. It then judges the result by draining the counter and counting exactly how many later pops succeed. In the second, a pop frees a slot in a full counter while the pushing stage waits. The bench checks that the acknowledgement stays low in the pop cycle and rises in the cycle after it.

// File: rtl/dep_sync_pkg.sv
package dep_sync_pkg;

    localparam int NUM_STAGES = 3;
    localparam int NUM_QUEUES = 4;
    localparam int FLAG_W     = 4;

    // stage indices
    localparam int STG_LOAD  = 0;
    localparam int STG_COMP  = 1;
    localparam int STG_STORE = 2;

    // queue indices
    localparam int Q_L2C = 0;
    localparam int Q_C2L = 1;
    localparam int Q_C2S = 2;
    localparam int Q_S2C = 3;

    typedef struct packed {
        logic take_prev;   // bit 3
        logic take_next;   // bit 2
        logic give_prev;   // bit 1
        logic give_next;   // bit 0
    } dep_flags_t;

    typedef logic [NUM_QUEUES-1:0] qmask_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } stage_state_e;

    // Counters an instruction of a given stage must pop before starting.
    function automatic qmask_t take_mask(int stg, dep_flags_t f);
        qmask_t m = '0;
        case (stg)
            STG_LOAD: m[Q_C2L] = f.take_next;
            STG_COMP: begin
                m[Q_L2C] = f.take_prev;
                m[Q_S2C] = f.take_next;
            end
            STG_STORE: m[Q_C2S] = f.take_prev;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Counters an instruction of a given stage pushes on completion.
    function automatic qmask_t give_mask(int stg, dep_flags_t f);
        qmask_t m = '0;
        case (stg)
            STG_LOAD: m[Q_L2C] = f.give_next;
            STG_COMP: begin
                m[Q_C2L] = f.give_prev;
                m[Q_C2S] = f.give_next;
            end
            STG_STORE: m[Q_S2C] = f.give_prev;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dep_token_queue.sv
module dep_token_queue #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    output logic empty,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   if (count != TOP) count <= count + 1'b1;
                2'b01:   if (count != '0)  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign empty = (count == '0);
    assign full  = (count == TOP);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R8
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (count == $past(count)));

    // R7
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= TOP);

endmodule

// File: rtl/dep_stage_ctrl.sv
module dep_stage_ctrl
    import dep_sync_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid,
    input  dep_flags_t issue_flags,
    input  logic       done,
    input  qmask_t     q_empty,
    input  qmask_t     q_full,
    output logic       start,
    output logic       done_ack,
    output qmask_t     pop_req,
    output qmask_t     push_req
);
    stage_state_e state;
    qmask_t       give_lat;
    qmask_t       need;

    assign need     = take_mask(STAGE, issue_flags);
    assign start    = (state == ST_IDLE) && issue_valid && ((need & q_empty) == '0);
    assign pop_req  = start ? need : '0;
    assign done_ack = (state == ST_BUSY) && done && ((give_lat & q_full) == '0);
    assign push_req = done_ack ? give_lat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            give_lat <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_BUSY;
                    give_lat <= give_mask(STAGE, issue_flags);
                end
                ST_BUSY: if (done_ack) begin
                    state    <= ST_IDLE;
                    give_lat <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY) |-> !start);

    // R3
    grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_BUSY));

    // R4
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done_ack |=> !done_ack);

endmodule

// File: rtl/dep_token_sync.sv
module dep_token_sync
    import dep_sync_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_STAGES-1:0]        issue_valid,
    input  logic [NUM_STAGES*FLAG_W-1:0] issue_flags,
    output logic [NUM_STAGES-1:0]        start,
    input  logic [NUM_STAGES-1:0]        done,
    output logic [NUM_STAGES-1:0]        done_ack
);
    qmask_t q_empty, q_full;
    qmask_t pop_req  [NUM_STAGES];
    qmask_t push_req [NUM_STAGES];
    qmask_t pop_any, push_any;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        dep_stage_ctrl #(.STAGE(s)) i_ctrl (
            .clk         (clk),
            .rst         (rst),
            .issue_valid (issue_valid[s]),
            .issue_flags (dep_flags_t'(issue_flags[s*FLAG_W +: FLAG_W])),
            .done        (done[s]),
            .q_empty     (q_empty),
            .q_full      (q_full),
            .start       (start[s]),
            .done_ack    (done_ack[s]),
            .pop_req     (pop_req[s]),
            .push_req    (push_req[s])
        );
    end

    always_comb begin
        pop_any  = '0;
        push_any = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            pop_any  |= pop_req[s];
            push_any |= push_req[s];
        end
    end

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        dep_token_queue #(.DEPTH(QDEPTH)) i_queue (
            .clk   (clk),
            .rst   (rst),
            .push  (push_any[q]),
            .pop   (pop_any[q]),
            .empty (q_empty[q]),
            .full  (q_full[q])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (done_ack == '0));

endmodule

// File: tb/test_dep_token_sync.sv
`timescale 1ns/1ps
module test_dep_token_sync;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  issue_valid = '0;
    logic [11:0] issue_flags = '0;
    logic [2:0]  start;
    logic [2:0]  done = '0;
    logic [2:0]  done_ack;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dep_token_sync i_dep_token_sync (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_flags(issue_flags),
        .start(start), .done(done), .done_ack(done_ack)
    );

    // flags: bit3 pop-prev, bit2 pop-next, bit1 push-prev, bit0 push-next
    // entry: {req[3:0], stage[1:0], flags[3:0], expect_start}
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {4'd2, 2'd0, 4'b0000, 1'b1},  // R2 load, no flags
        {4'd5, 2'd1, 4'b0010, 1'b1},  // R5 compute push-prev -> C2L
        {4'd5, 2'd0, 4'b0100, 1'b1},  // R5 load pop-next consumes
        {4'd3, 2'd0, 4'b0100, 1'b0},  // R3 C2L empty again
        {4'd6, 2'd0, 4'b0001, 1'b1},  // R6 load push-next -> L2C
        {4'd6, 2'd1, 4'b1000, 1'b1},  // R6 compute pop-prev
        {4'd3, 2'd1, 4'b1000, 1'b0},  // R3 L2C empty
        {4'd6, 2'd1, 4'b0001, 1'b1},  // R6 compute push-next -> C2S
        {4'd6, 2'd2, 4'b1000, 1'b1},  // R6 store pop-prev
        {4'd6, 2'd2, 4'b0010, 1'b1},  // R6 store push-prev -> S2C
        {4'd6, 2'd1, 4'b0100, 1'b1},  // R6 compute pop-next
        {4'd9, 2'd2, 4'b0100, 1'b1},  // R9 store pop-next ignored
        {4'd9, 2'd0, 4'b0010, 1'b1},  // R9 load push-prev ignored
        {4'd9, 2'd0, 4'b0100, 1'b0}   // R9 nothing reached C2L
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // issue at a negedge, check grant, then complete if granted
    task automatic run_instr(input int s, input logic [3:0] f, input logic exp, input string tag);
        @(negedge clk);
        issue_valid[s] = 1'b1;
        issue_flags[4*s +: 4] = f;
        #1;
        chk(start[s], exp, {tag, " start"});
        @(negedge clk);
        issue_valid[s] = 1'b0;
        issue_flags[4*s +: 4] = '0;
        if (exp) begin
            done[s] = 1'b1;
            #1;
            chk(done_ack[s], 1'b1, {tag, " done_ack"});
            @(negedge clk);
            done[s] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state: no token anywhere, idle stage not acked
        issue_valid[1] = 1'b1;
        issue_flags[7:4] = 4'b1000;
        done[2] = 1'b1;
        #1;
        chk(start[1], 1'b0, "R1 compute pop-prev after reset");
        chk(done_ack[2], 1'b0, "R1 idle store done");
        @(negedge clk);
        issue_valid[1] = 1'b0;
        issue_flags = '0;
        done[2] = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            automatic logic [10:0] v = VEC[i];
            run_instr(int'(v[6:5]), v[4:1], v[0], $sformatf("R%0d vec%0d", v[10:7], i));
        end

        // R9 busy stage not restarted; R4 long instruction pushes once
        @(negedge clk);
        issue_valid[1] = 1'b1;
        issue_flags[7:4] = 4'b0010;
        #1;
        chk(start[1], 1'b1, "R4 compute start");
        @(negedge clk);
        #1;
        chk(start[1], 1'b0, "R9 busy no restart");
        issue_valid[1] = 1'b0;
        issue_flags = '0;
        repeat (4) @(negedge clk);
        done[1] = 1'b1;
        #1;
        chk(done_ack[1], 1'b1, "R4 late done ack");
        @(negedge clk);
        done[1] = 1'b0;
        run_instr(0, 4'b0100, 1'b1, "R4 one token present");
        run_instr(0, 4'b0100, 1'b0, "R4 only one token pushed");

        // R3 double pop needs both counters
        run_instr(0, 4'b0001, 1'b1, "R3 seed L2C");
        run_instr(1, 4'b1100, 1'b0, "R3 S2C missing");
        run_instr(2, 4'b0010, 1'b1, "R3 seed S2C");
        run_instr(1, 4'b1100, 1'b1, "R3 both present");
        run_instr(1, 4'b1000, 1'b0, "R3 L2C consumed");
        run_instr(1, 4'b0100, 1'b0, "R3 S2C consumed");

        // R8 push and pop on C2L in one cycle
        run_instr(1, 4'b0010, 1'b1, "R8 seed C2L");
        @(negedge clk);
        issue_valid[1] = 1'b1;
        issue_flags[7:4] = 4'b0010;
        @(negedge clk);
        issue_valid[1] = 1'b0;
        issue_flags = '0;
        done[1] = 1'b1;
        issue_valid[0] = 1'b1;
        issue_flags[3:0] = 4'b0100;
        #1;
        chk(start[0], 1'b1, "R8 pop granted");
        chk(done_ack[1], 1'b1, "R8 push acked");
        @(negedge clk);
        done[1] = 1'b0;
        issue_valid[0] = 1'b0;
        issue_flags = '0;
        done[0] = 1'b1;
        @(negedge clk);
        done[0] = 1'b0;
        run_instr(0, 4'b0100, 1'b1, "R8 count still one");
        run_instr(0, 4'b0100, 1'b0, "R8 count now zero");

        // R7 fill C2L to 8, ninth push stalls
        for (int k = 0; k < 8; k++) run_instr(1, 4'b0010, 1'b1, "R7 fill");
        @(negedge clk);
        issue_valid[1] = 1'b1;
        issue_flags[7:4] = 4'b0010;
        @(negedge clk);
        issue_valid[1] = 1'b0;
        issue_flags = '0;
        done[1] = 1'b1;
        #1;
        chk(done_ack[1], 1'b0, "R7 full stalls ack");
        @(negedge clk);
        #1;
        chk(done_ack[1], 1'b0, "R7 still stalled");
        @(negedge clk);
        issue_valid[0] = 1'b1;
        issue_flags[3:0] = 4'b0100;
        #1;
        chk(start[0], 1'b1, "R7 pop from full");
        chk(done_ack[1], 1'b0, "R7 no ack in pop cycle");
        @(negedge clk);
        issue_valid[0] = 1'b0;
        issue_flags = '0;
        done[0] = 1'b1;
        #1;
        chk(done_ack[1], 1'b1, "R7 ack after room");
        @(negedge clk);
        done[0] = 1'b0;
        done[1] = 1'b0;
        for (int k = 0; k < 8; k++) run_instr(0, 4'b0100, 1'b1, "R7 drain");
        run_instr(0, 4'b0100, 1'b0, "R7 drained to empty");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule